// File: doc/BRIEF.md
# Power Button Event Controller

This block watches an active-low power button and turns each qualified press into a power-management action that depends on the current system power state. The raw button first passes through a two-flop synchronizer. A debounce filter then counts millisecond ticks derived from the input clock. The falling edge of the filtered level is the press event, and the action starts on that edge without waiting for the button to be released.

In the working state a press raises a one-cycle SMI or SCI pulse, chosen by the SCI-enable input. In sleep states 1 to 5 a press raises a one-cycle wake request. That wake is withheld while the deepest-sleep signal is being stretched to its minimum width. In mechanical-off a press does nothing at all. A separate hold timer runs for as long as the filtered button stays low. Once the hold reaches the configured time, the block issues a single forced soft-off pulse, provided the state code is 0 to 4. This pulse needs no acknowledgement from any other logic. A sticky status bit records each press that produced an event, until software clears it.

Top module: `pwr_button_ctrl`

## Requirements
- R1: The filtered button level changes only after the synchronized raw input has differed from it for DEBOUNCE_MS consecutive millisecond ticks. Any return to the old level restarts the count, so a shorter glitch has no effect on any output.
- R2: The action for a press is issued on the filtered falling edge while the button is still held. It does not wait for release.
- R3: In state code 0 (working), a press gives a one-cycle `smi_evt` pulse when `sci_en` is 0, or a one-cycle `sci_evt` pulse when `sci_en` is 1. Never both.
- R4: In state codes 1 to 5 (sleep levels), a press gives a one-cycle `wake_req` pulse.
- R5: In state code 7 (mechanical off), a press gives no pulse on any output and does not set `press_sts`.
- R6: While the filtered button stays low for HOLD_MS ticks, `force_off` pulses for one cycle if the state code is 0 to 4 at that moment. It does not pulse for state codes 5 or 7.
- R7: `force_off` fires at most once per continuous hold. Releasing the button re-arms the hold timer.
- R8: While `slp_stretch` is 1, a press in a sleep state produces no `wake_req`.
- R9: `press_sts` is set by any SMI, SCI or wake event and stays set until `sts_clr` is 1. A new event in the same cycle as the clear wins.
- R10: After reset, all pulse outputs and `press_sts` are 0 and the button is treated as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_raw_n | input | 1 | Raw power button, low when pressed |
| sys_state | input | 3 | Power state code: 0 working, 1-5 sleep levels, 7 mechanical off |
| sci_en | input | 1 | Selects SCI (1) or SMI (0) for a working-state press |
| slp_stretch | input | 1 | Deepest-sleep signal is held for its minimum width |
| sts_clr | input | 1 | Clears the sticky press status |
| smi_evt | output | 1 | One-cycle SMI request |
| sci_evt | output | 1 | One-cycle SCI request |
| wake_req | output | 1 | One-cycle request to return to the working state |
| force_off | output | 1 | One-cycle unconditional soft-off request |
| press_sts | output | 1 | Sticky record of an event-producing press |

## Verification
The bench shortens the millisecond tick to four clocks and compares every output each cycle against a behavioural model. It also counts pulses per scenario. A glitch shorter than the debounce window is injected: a filter that forgets to restart its count, or reacts to raw edges, would emit a spurious SMI. Presses are made in every class of state, including mechanical-off and a sleep state with stretching active. These catch a decoder that wakes from off, wakes during stretching, or swaps SMI and SCI. A long hold in the working state checks for exactly one soft-off pulse, and one in state 5 checks for none. A timer that re-fires every tick or ignores the state gate would show up in these counts.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  typedef enum logic [2:0] {
    PS_WORK  = 3'd0,
    PS_SL1   = 3'd1,
    PS_SL2   = 3'd2,
    PS_SL3   = 3'd3,
    PS_SL4   = 3'd4,
    PS_SL5   = 3'd5,
    PS_RSVD  = 3'd6,
    PS_MECH  = 3'd7
  } pstate_e;

  function automatic logic is_sleep(input logic [2:0] s);
    return (s >= 3'd1) && (s <= 3'd5);
  endfunction

  function automatic logic hold_allowed(input logic [2:0] s);
    return s <= 3'd4;
  endfunction
endpackage

// File: rtl/pbc_tick_gen.sv
module pbc_tick_gen #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt <= '0;
        else if (cnt == CW'(DIV - 1))  cnt <= '0;
        else                           cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/pbc_debounce.sv
module pbc_debounce #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_n,
  output logic level_n
);
  localparam int CW = $clog2(TICKS + 1);
  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= raw_n;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_n <= 1'b1;
      cnt     <= '0;
    end else if (s2 == level_n) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == CW'(TICKS - 1)) begin
        level_n <= s2;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_level_follows_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_n) |-> (level_n == $past(s2)) && $past(tick));
endmodule

// File: rtl/pbc_hold_timer.sv
module pbc_hold_timer #(
  parameter int TICKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level_n,
  output logic expire
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt;
  logic          spent;

  assign expire = !level_n && tick && !spent && (cnt == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      spent <= 1'b0;
    end else if (level_n) begin
      cnt   <= '0;
      spent <= 1'b0;
    end else if (tick && !spent) begin
      if (expire) spent <= 1'b1;
      else        cnt   <= cnt + 1'b1;
    end
  end

  assert_expire_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> spent);
endmodule

// File: rtl/pwr_button_ctrl.sv
module pwr_button_ctrl
  import pbc_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int DEBOUNCE_MS = 16,
  parameter int HOLD_MS     = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_raw_n,
  input  logic [2:0] sys_state,
  input  logic       sci_en,
  input  logic       slp_stretch,
  input  logic       sts_clr,
  output logic       smi_evt,
  output logic       sci_evt,
  output logic       wake_req,
  output logic       force_off,
  output logic       press_sts
);
  localparam int TICK_DIV = CLK_HZ / 1000;

  logic tick, level_n, level_q, press, expire;
  logic go_smi, go_sci, go_wake, go_sts;

  pbc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pbc_debounce #(.TICKS(DEBOUNCE_MS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw_n(btn_raw_n), .level_n(level_n)
  );

  pbc_hold_timer #(.TICKS(HOLD_MS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level_n(level_n), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= level_n;
  end

  assign press   = level_q && !level_n;
  assign go_smi  = press && (sys_state == PS_WORK) && !sci_en;
  assign go_sci  = press && (sys_state == PS_WORK) && sci_en;
  assign go_wake = press && is_sleep(sys_state) && !slp_stretch;
  assign go_sts  = go_smi || go_sci || go_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_evt   <= 1'b0;
      sci_evt   <= 1'b0;
      wake_req  <= 1'b0;
      force_off <= 1'b0;
      press_sts <= 1'b0;
    end else begin
      smi_evt   <= go_smi;
      sci_evt   <= go_sci;
      wake_req  <= go_wake;
      force_off <= expire && hold_allowed(sys_state);
      press_sts <= go_sts || (press_sts && !sts_clr);
    end
  end

  assert_event_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smi_evt, sci_evt, wake_req}));
  assert_smi_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smi_evt |=> !smi_evt);
  assert_mech_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_evt || sci_evt || wake_req) |-> ($past(sys_state) != PS_MECH));
  assert_force_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> !force_off);
  assert_force_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> ($past(sys_state) <= 3'd4));
  assert_no_wake_stretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !$past(slp_stretch));
  assert_sts_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_evt || sci_evt || wake_req) |-> press_sts);
endmodule

// File: tb/pwr_button_ctrl_bench.sv
module pwr_button_ctrl_bench;
  localparam int CLK_HZ = 4000;
  localparam int DIV    = 4;
  localparam int DEB    = 3;
  localparam int HOLD   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_raw_n = 1'b1;
  logic [2:0] sys_state = 3'd0;
  logic sci_en = 1'b0, slp_stretch = 1'b0, sts_clr = 1'b0;
  logic smi_evt, sci_evt, wake_req, force_off, press_sts;

  int total = 0, bad = 0, cycles = 0;
  int n_smi = 0, n_sci = 0, n_wake = 0, n_force = 0;

  // behavioural reference state
  int m_tc = 0, m_dc = 0, m_hc = 0;
  bit m_s1 = 1, m_s2 = 1, m_db = 1, m_prev = 1, m_spent = 0;
  bit e_smi = 0, e_sci = 0, e_wake = 0, e_force = 0, e_sts = 0;

  always #10 clk = ~clk;

  pwr_button_ctrl #(.CLK_HZ(CLK_HZ), .DEBOUNCE_MS(DEB), .HOLD_MS(HOLD)) u_pwr_button_ctrl (
    .clk(clk), .rst_n(rst_n), .btn_raw_n(btn_raw_n), .sys_state(sys_state),
    .sci_en(sci_en), .slp_stretch(slp_stretch), .sts_clr(sts_clr),
    .smi_evt(smi_evt), .sci_evt(sci_evt), .wake_req(wake_req),
    .force_off(force_off), .press_sts(press_sts)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tc = 0; m_dc = 0; m_hc = 0; m_s1 = 1; m_s2 = 1; m_db = 1; m_prev = 1; m_spent = 0;
      e_smi = 0; e_sci = 0; e_wake = 0; e_force = 0; e_sts = 0;
    end else begin
      bit tk, pr, fire;
      tk = (m_tc == DIV - 1);
      pr = m_prev && !m_db;
      fire = !m_db && tk && !m_spent && (m_hc == HOLD - 1);
      e_smi  = pr && sys_state == 0 && !sci_en;
      e_sci  = pr && sys_state == 0 && sci_en;
      e_wake = pr && sys_state >= 1 && sys_state <= 5 && !slp_stretch;
      e_force = fire && sys_state <= 4;
      e_sts  = e_smi || e_sci || e_wake || (e_sts && !sts_clr);
      if (m_db) begin m_hc = 0; m_spent = 0; end
      else if (tk && !m_spent) begin
        if (fire) m_spent = 1; else m_hc++;
      end
      m_prev = m_db;
      if (m_s2 == m_db) m_dc = 0;
      else if (tk) begin
        if (m_dc == DEB - 1) begin m_db = m_s2; m_dc = 0; end
        else m_dc++;
      end
      m_s2 = m_s1;
      m_s1 = btn_raw_n;
      m_tc = tk ? 0 : m_tc + 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R3 smi_evt model", smi_evt, e_smi);
      check("R3 sci_evt model", sci_evt, e_sci);
      check("R4 wake_req model", wake_req, e_wake);
      check("R6 force_off model", force_off, e_force);
      check("R9 press_sts model", press_sts, e_sts);
      n_smi += smi_evt; n_sci += sci_evt; n_wake += wake_req; n_force += force_off;
    end
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic zero_counts();
    n_smi = 0; n_sci = 0; n_wake = 0; n_force = 0;
  endtask

  // hold low for len cycles, return event count seen before release
  task automatic press_for(input int len, output int before_rel);
    btn_raw_n = 1'b0;
    wait_cyc(len);
    before_rel = n_smi + n_sci + n_wake;
    btn_raw_n = 1'b1;
    wait_cyc(40);
  endtask

  initial begin
    int br;
    wait_cyc(3);
    check("R10 reset smi", smi_evt, 1'b0);
    check("R10 reset force", force_off, 1'b0);
    check("R10 reset sts", press_sts, 1'b0);
    rst_n = 1'b1;
    wait_cyc(10);

    // R3 SMI in working state, R2 action before release
    zero_counts(); sys_state = 3'd0; sci_en = 1'b0;
    press_for(30, br);
    check_int("R2 event before release", br, 1);
    check_int("R3 smi count", n_smi, 1);
    check_int("R3 sci count", n_sci, 0);

    // R3 SCI
    zero_counts(); sci_en = 1'b1;
    press_for(30, br);
    check_int("R3 sci count", n_sci, 1);
    check_int("R3 smi count sci mode", n_smi, 0);

    // R1 glitch ignored
    zero_counts(); sci_en = 1'b0;
    btn_raw_n = 1'b0; wait_cyc(5); btn_raw_n = 1'b1; wait_cyc(40);
    check_int("R1 glitch no event", n_smi + n_sci + n_wake, 0);

    // R9 clear
    sts_clr = 1'b1; wait_cyc(1); sts_clr = 1'b0; wait_cyc(1);
    check("R9 cleared", press_sts, 1'b0);

    // R4 wake from sleep 3
    zero_counts(); sys_state = 3'd3;
    press_for(30, br);
    check_int("R4 wake count", n_wake, 1);
    check("R9 sts after wake", press_sts, 1'b1);
    sts_clr = 1'b1; wait_cyc(1); sts_clr = 1'b0; wait_cyc(1);

    // R8 stretch suppresses wake in state 5
    zero_counts(); sys_state = 3'd5; slp_stretch = 1'b1;
    press_for(30, br);
    check_int("R8 no wake while stretch", n_wake, 0);
    check("R8 sts unchanged", press_sts, 1'b0);
    slp_stretch = 1'b0;
    zero_counts();
    press_for(30, br);
    check_int("R4 wake state5", n_wake, 1);
    sts_clr = 1'b1; wait_cyc(1); sts_clr = 1'b0; wait_cyc(1);

    // R5 mechanical off
    zero_counts(); sys_state = 3'd7;
    press_for(80, br);
    check_int("R5 no events in off", n_smi + n_sci + n_wake + n_force, 0);
    check("R5 sts not set", press_sts, 1'b0);

    // R6 R7 long hold in working state
    zero_counts(); sys_state = 3'd0;
    press_for(120, br);
    check_int("R6 force once", n_force, 1);
    check_int("R7 single smi on hold", n_smi, 1);
    zero_counts();
    press_for(120, br);
    check_int("R7 re-armed after release", n_force, 1);

    // R6 no force in state 5
    zero_counts(); sys_state = 3'd5;
    press_for(120, br);
    check_int("R6 no force in state5", n_force, 0);
    check_int("R4 wake on long hold", n_wake, 1);

    // R9 set wins over clear
    zero_counts(); sys_state = 3'd0; sts_clr = 1'b1;
    press_for(30, br);
    sts_clr = 1'b0; wait_cyc(2);
    check("R9 clear held gives 0 after", press_sts, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule